// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

This block is an 8-bit up-counter driven by a prescaler. Software picks the prescaler division from a fixed set of eight. The counter wraps from 0xFF to 0x00. Each wrap sets a sticky overflow flag. A mode bit decides what the wrap does. In interval mode it raises a level interrupt request to the CPU. In watchdog mode it fires a fixed-length overflow pulse, and can also fire an internal reset request.

Software reaches the block through a simple register port. Every write is a 16-bit word, and its upper byte is a key that picks the target. Key 0xA5 writes the control/status byte. Key 0x5A reloads the counter, which is how the watchdog is serviced. Any other key drops the write. The overflow flag can only be cleared in three ways:
- software reads it while it is set, then writes 0 to it;
- software disables the timer;
- the internal reset it triggered completes.

Top module: `wdt_top`

## Requirements
- R1: After reset the control byte reads 0x18, the counter reads 0x00, and `intervalIrq`, `wdogOvf` and `intReset` are low.
- R2: A write whose upper byte is 0xA5 loads the control byte. A write with upper byte 0x5A loads the counter. A write with any other upper byte changes neither register.
- R3: Control byte layout, by bit:
  - bit 7: overflow flag;
  - bit 6: mode, where 1 is watchdog;
  - bit 5: run enable;
  - bits 4:3: always read as 1 and ignore writes;
  - bits 2:0: prescaler tap.
  
  Writing 1 to bit 7 never sets the flag.
- R4: While bit 5 is 0, the counter is held at 0x00 and counter writes have no effect.
- R5: Tap codes 0 to 7 divide the clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. While running, the counter advances exactly once per divisor cycles.
- R6: A counter step from 0xFF to 0x00 sets bit 7.
- R7: Bit 7 is cleared by a control write with bit 7 = 0 only if the control byte was read while bit 7 was 1, after the last control write. A write without such a read leaves the flag set.
- R8: A control write with bit 5 = 0 clears bit 7.
- R9: `intervalIrq` is high exactly while bit 7 is 1 and bit 6 is 0.
- R10: In watchdog mode, an overflow drives `wdogOvf` high for exactly 132 clock cycles and leaves `intervalIrq` low.
- R11: If `resetEnable` is high when a watchdog overflow occurs, `intReset` follows that pulse, and the flag clears when the pulse ends. If `resetEnable` is low, `intReset` stays low and the flag stays set.
- R12: `busRdata` shows the control byte when `busAddr` is 0 and the counter when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| busWr | input | 1 | Write strobe for one 16-bit keyed word |
| busWdata | input | 16 | Key in bits 15:8, data in bits 7:0 |
| busRd | input | 1 | Read strobe; a read arms the flag-clear sequence |
| busAddr | input | 1 | Read select: 0 control byte, 1 counter |
| busRdata | output | 8 | Read data |
| resetEnable | input | 1 | Allows a watchdog overflow to request an internal reset |
| intervalIrq | output | 1 | Interval interrupt request |
| wdogOvf | output | 1 | Watchdog overflow pulse |
| intReset | output | 1 | Internal reset request |

## Verification
Keyed writes are tried with random upper bytes, so keys outside the two valid values show up as discarded, and random counter reloads show the counter key works. Counting is checked with random taps over windows of whole divisor periods; an off-by-one tap decode then shows up as a wrong step count. The overflow flag is driven through three sequences that separate a blind zero-write, a read-armed clear and a disable clear. Watchdog overflows are run with the reset enable low and high; together these separate pulse width, interrupt masking and the automatic flag clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W     = 8;
  localparam int PRE_W     = 17;
  localparam int PULSE_LEN = 132;
  localparam int PULSE_W   = $clog2(PULSE_LEN + 1);
  localparam logic [7:0] CTRL_KEY = 8'hA5;
  localparam logic [7:0] CNT_KEY  = 8'h5A;
  localparam logic [7:0] CTRL_RST = 8'h18;

  // strobes from control to datapath
  typedef struct packed {
    logic             run;
    logic [2:0]       tap;
    logic             cntLoad;
    logic [CNT_W-1:0] cntLoadVal;
    logic             pulseStart;
  } ctlStrobes_t;

  // log2 of the prescaler divisor for each tap code
  function automatic int tapExp(input logic [2:0] tap);
    case (tap)
      3'd0: tapExp = 1;
      3'd1: tapExp = 6;
      3'd2: tapExp = 7;
      3'd3: tapExp = 9;
      3'd4: tapExp = 11;
      3'd5: tapExp = 13;
      3'd6: tapExp = 15;
      default: tapExp = 17;
    endcase
  endfunction
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  output logic [CNT_W-1:0] cnt,
  output logic             ovfEvt,
  output logic             pulseActive,
  output logic             pulseLast
);
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   tapMask;
  logic               tick;
  logic [PULSE_W-1:0] pulseCnt;

  always_comb begin
    tapMask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < tapExp(ctl.tap)) tapMask[i] = 1'b1;
    end
  end

  assign tick   = ctl.run && ((preCnt & tapMask) == tapMask);
  assign ovfEvt = tick && !ctl.cntLoad && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         preCnt <= '0;
    else if (!ctl.run) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (!ctl.run)    cnt <= '0;
    else if (ctl.cntLoad) cnt <= ctl.cntLoadVal;
    else if (tick)        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseCnt <= '0;
    else if (ctl.pulseStart) pulseCnt <= PULSE_W'(PULSE_LEN);
    else if (pulseCnt != 0)  pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseActive = (pulseCnt != 0);
  assign pulseLast   = (pulseCnt == PULSE_W'(1));
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [15:0]      busWdata,
  input  logic             busRd,
  input  logic             busAddr,
  input  logic             resetEnable,
  input  logic             ovfEvt,
  input  logic             pulseActive,
  input  logic             pulseLast,
  output ctlStrobes_t      ctl,
  output logic [7:0]       ctrlVal,
  output logic             intervalIrq,
  output logic             intReset
);
  logic       ovfFlag, modeWd, runEn, armed, rstPend;
  logic [2:0] tapSel;
  logic       ctrlWr, cntWr;

  assign ctrlWr = busWr && (busWdata[15:8] == CTRL_KEY);
  assign cntWr  = busWr && (busWdata[15:8] == CNT_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWd <= CTRL_RST[6];
      runEn  <= CTRL_RST[5];
      tapSel <= CTRL_RST[2:0];
    end else if (ctrlWr) begin
      modeWd <= busWdata[6];
      runEn  <= busWdata[5];
      tapSel <= busWdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            ovfFlag <= CTRL_RST[7];
    else if (ctrlWr && !busWdata[5])      ovfFlag <= 1'b0;
    else if (ovfEvt)                      ovfFlag <= 1'b1;
    else if (ctrlWr && armed && !busWdata[7]) ovfFlag <= 1'b0;
    else if (pulseLast && rstPend)        ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 armed <= 1'b0;
    else if (ctrlWr)                           armed <= 1'b0;
    else if (busRd && !busAddr && ovfFlag)     armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rstPend <= 1'b0;
    else if (ctl.pulseStart) rstPend <= resetEnable;
    else if (pulseLast)      rstPend <= 1'b0;
  end

  always_comb begin
    ctl.run        = runEn;
    ctl.tap        = tapSel;
    ctl.cntLoad    = cntWr;
    ctl.cntLoadVal = busWdata[7:0];
    ctl.pulseStart = ovfEvt && modeWd;
  end

  assign ctrlVal     = {ovfFlag, modeWd, runEn, 2'b11, tapSel};
  assign intervalIrq = ovfFlag && !modeWd;
  assign intReset    = pulseActive && rstPend;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [15:0] busWdata,
  input  logic        busRd,
  input  logic        busAddr,
  output logic [7:0]  busRdata,
  input  logic        resetEnable,
  output logic        intervalIrq,
  output logic        wdogOvf,
  output logic        intReset
);
  ctlStrobes_t      ctl;
  logic [CNT_W-1:0] cntVal;
  logic [7:0]       ctrlVal;
  logic             ovfEvt, pulseActive, pulseLast;

  wdt_control u_control (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busWdata(busWdata),
    .busRd(busRd), .busAddr(busAddr), .resetEnable(resetEnable),
    .ovfEvt(ovfEvt), .pulseActive(pulseActive), .pulseLast(pulseLast),
    .ctl(ctl), .ctrlVal(ctrlVal), .intervalIrq(intervalIrq),
    .intReset(intReset)
  );

  wdt_datapath u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cnt(cntVal),
    .ovfEvt(ovfEvt), .pulseActive(pulseActive), .pulseLast(pulseLast)
  );

  assign wdogOvf  = pulseActive;
  assign busRdata = busAddr ? cntVal : ctrlVal;
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks
  import wdt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic [15:0] busWdata,
  input logic [7:0]  ctrlVal,
  input logic [7:0]  cntVal,
  input logic        wdogOvf
);
  logic [15:0] hiRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiRun <= '0;
    else if (wdogOvf) hiRun <= hiRun + 1'b1;
    else              hiRun <= '0;
  end

  AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busWdata[15:8] != CTRL_KEY && busWdata[15:8] != CNT_KEY)
      |=> $stable(ctrlVal[6:0])); // R2
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlVal[5] |=> (cntVal == 8'h00)); // R4
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlVal[7]) |-> ($past(cntVal) == 8'hFF && cntVal == 8'h00)); // R6
  AST_PULSE_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogOvf) |-> ctrlVal[7]); // R10
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdogOvf) |-> (hiRun == 16'(PULSE_LEN))); // R10
endmodule

bind wdt_top wdt_checks u_checks (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busWdata(busWdata),
  .ctrlVal(ctrlVal), .cntVal(cntVal), .wdogOvf(wdogOvf)
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rstN = 0, busWr = 0, busRd = 0, busAddr = 0;
  logic [15:0] busWdata = '0;
  logic        resetEnable = 0;
  logic [7:0]  busRdata;
  logic        intervalIrq, wdogOvf, intReset;
  int compared = 0, mismatched = 0;

  wdt_top i_wdt_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expCtrl(input logic ovf, input logic wd,
                                         input logic run, input logic [2:0] tap);
    return {ovf, wd, run, 2'b11, tap};
  endfunction

  function automatic int divOf(input int tap);
    int e[8] = '{1, 6, 7, 9, 11, 13, 15, 17};
    return 1 << e[tap];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); busWr = 1; busWdata = d;
    @(negedge clk); busWr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); busRd = 1; busAddr = a; #1 v = busRdata;
    @(negedge clk); busRd = 0;
  endtask

  task automatic waitHigh(input int which, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((which == 0 && intervalIrq) || (which == 1 && wdogOvf) ||
          (which == 2 && intReset)) return;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] v, v1, v2, rk;
    int w, seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    rd(0, v); check("R1 ctrl", v, 8'h18);
    rd(1, v); check("R1 cnt", v, 8'h00);
    check("R1 outs", {intervalIrq, wdogOvf, intReset}, 3'b000);

    // R4: disabled counter ignores reloads
    wr(16'h5A33); rd(1, v); check("R4 held", v, 8'h00);

    // R3: fixed bits and no software set of the flag; slowest tap
    wr({8'hA5, 8'b1010_0111}); rd(0, v); check("R3 layout", v, expCtrl(0, 0, 1, 7));

    // R2: random bad keys are dropped
    for (int i = 0; i < 16; i++) begin
      do rk = 8'($urandom); while (rk == 8'hA5 || rk == 8'h5A);
      wr({rk, 8'($urandom)});
      rd(0, v); check("R2 badkey ctrl", v, expCtrl(0, 0, 1, 7));
      rd(1, v); check("R2 badkey cnt", v, 8'h00);
    end
    // R2 R12: counter reloads
    for (int i = 0; i < 4; i++) begin
      rk = 8'($urandom);
      wr({8'h5A, rk}); rd(1, v); check("R2 R12 reload", v, rk);
    end

    // R5: step rate over whole divisor windows
    for (int i = 0; i < 5; i++) begin
      int t = (i == 0) ? 0 : int'($urandom % 3);
      wr({8'hA5, 5'b00100, 3'(t)});
      wr(16'h5A10);
      busAddr = 1;
      @(negedge clk); #1 v1 = busRdata;
      repeat (3 * divOf(t)) @(negedge clk);
      #1 v2 = busRdata;
      check($sformatf("R5 tap%0d", t), v2 - v1, 8'd3);
    end

    // R6 R9 R7: interval overflow and clear protocol
    wr(16'hA520); wr(16'h5AFD);
    waitHigh(0, 100);
    check("R9 irq up", intervalIrq, 1'b1);
    wr(16'hA520);
    check("R7 blind clear ignored", intervalIrq, 1'b1);
    rd(0, v); check("R6 flag set", v, expCtrl(1, 0, 1, 0));
    wr(16'hA520);
    rd(0, v); check("R7 armed clear", v, expCtrl(0, 0, 1, 0));
    check("R9 irq down", intervalIrq, 1'b0);

    // R8: disable clears the flag
    waitHigh(0, 600);
    check("R8 flag again", intervalIrq, 1'b1);
    wr(16'hA500);
    rd(0, v); check("R8 disable clear", v, 8'h18);
    rd(1, v); check("R4 cnt zero", v, 8'h00);

    // R10 R11: watchdog without internal reset
    resetEnable = 0;
    wr(16'hA560); wr(16'h5AFE);
    waitHigh(1, 100);
    w = 0; seen = 0;
    while (wdogOvf) begin
      w++; seen |= intervalIrq | (intReset << 1);
      @(negedge clk);
    end
    check("R10 pulse width", w, 132);
    check("R10 R11 no irq no reset", seen, 0);
    rd(0, v); check("R11 flag kept", v, expCtrl(1, 1, 1, 0));

    // R11: watchdog with internal reset
    wr(16'hA500); resetEnable = 1;
    wr(16'hA560); wr(16'h5AFE);
    waitHigh(2, 100);
    w = 0;
    while (intReset) begin w++; @(negedge clk); end
    check("R11 reset width", w, 132);
    rd(0, v); check("R11 flag auto clear", v, expCtrl(0, 1, 1, 0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule